// File: doc/BRIEF.md
# Two-Level Routing Address Decoder

This block sits beside the command and response paths of a clustered interconnect. Every initiator and target shares one 32-bit address space. The block resolves a request address into three results: the cluster that owns the address, the target port inside that cluster, and a cacheability flag. The cluster comes from a global routing table keyed by the top address byte. The port comes from that cluster's own local routing table, keyed by the next four address bits.

On the response side, the block splits a 10-bit source identifier into the initiator's cluster number and its local number. The global and local tables are built at elaboration from parameters, and nothing writes them at run time. The cacheability flag depends only on the two address bits selected by the mask 0x000C0000. A four-entry class table turns those two bits into the flag.

By default, every output is registered once, and a valid bit travels with the outputs. Setting the pipeline parameter to zero makes the whole decode combinational.

Top module: `route_decoder`

## Requirements
- R1: Address bits [31:24] index the global table. With the default of four clusters, values 0, 1, 2 and 3 are populated and resolve to cluster 3, 2, 1 and 0 respectively.
- R2: Address bits [23:20] index the local table of the cluster found by R1. In cluster c, an index L is populated when L < c + 2, and it resolves to port (L + c + 3) mod 4.
- R3: The address bits [17:0] have no effect on any output. Bits [19:18] affect only the cacheability flag.
- R4: The cacheability flag equals the class-table bit selected by address bits [19:18]. By default, classes 1 and 2 are cacheable and classes 0 and 3 are not. For example, address 0x00050000 gives cluster 3, port 2, cacheable.
- R5: A global index of 4 or more sets the decode-error output and drives the cluster and port outputs to zero.
- R6: An unpopulated local entry in a populated cluster also sets the decode-error output, with the cluster and port outputs at zero.
- R7: The response cluster output equals source-identifier bits [9:2], and the response local output equals bits [1:0].
- R8: With the pipeline enabled (the default), every output appears exactly one cycle after its inputs, and the output-valid signal is the input-valid signal delayed by one cycle.
- R9: While reset is asserted, the output-valid signal and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input address and source identifier are valid |
| addr | input | 32 | Request address |
| srcid | input | 10 | Response source identifier |
| out_valid | output | 1 | Results are valid |
| clu_idx | output | 8 | Destination cluster index |
| port_idx | output | 2 | Destination port within the cluster |
| cacheable | output | 1 | Address class is cacheable |
| dec_err | output | 1 | No target holds this address |
| rsp_clu | output | 8 | Initiator cluster from the source identifier |
| rsp_loc | output | 2 | Initiator local index from the source identifier |

## Verification
The command decode and the response split both pass through the same output register in the same cycle. A fault in one can therefore hide behind a correct value in the other. Every vector drives a fresh address together with an unrelated source identifier. The scoreboard compares all six results of that vector in a single step, in the cycle after it was applied. Valid gaps between vectors, and back-to-back vectors that cross from a decode error to a hit, show whether the two results stay aligned with their own vector.

// File: rtl/route_pkg.sv
package route_pkg;

  // Global map: the first nclu global slots name clusters in reverse order.
  function automatic int glb_cluster(input int msb, input int nclu);
    return (msb < nclu) ? (nclu - 1 - msb) : -1;
  endfunction

  // Local map of cluster c: entries below c+2 are populated, port rotated by c+3.
  function automatic int loc_port(input int c, input int lsb, input int nports);
    return (lsb < c + 2) ? ((lsb + c + 3) % nports) : -1;
  endfunction

  // Lowest set bit of a mask word.
  function automatic int low_bit(input logic [63:0] m);
    int r;
    r = 0;
    for (int i = 63; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/glb_table.sv
module glb_table #(
  parameter int GLB_W   = 8,
  parameter int CLU_W   = 8,
  parameter int NUM_CLU = 4
) (
  input  logic [GLB_W-1:0] msb,
  output logic             hit,
  output logic [CLU_W-1:0] clu
);
  localparam int ENTRIES = 1 << GLB_W;

  logic             tbl_hit [ENTRIES];
  logic [CLU_W-1:0] tbl_clu [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam int C = route_pkg::glb_cluster(g, NUM_CLU);
    assign tbl_hit[g] = (C >= 0);
    assign tbl_clu[g] = (C >= 0) ? CLU_W'(C) : '0;
  end

  assign hit = tbl_hit[msb];
  assign clu = tbl_clu[msb];
endmodule

// File: rtl/loc_table.sv
module loc_table #(
  parameter int LOC_W   = 4,
  parameter int CLU_W   = 8,
  parameter int NUM_CLU = 4,
  parameter int PORTS   = 4,
  localparam int PORT_W = $clog2(PORTS)
) (
  input  logic               glb_hit,
  input  logic [CLU_W-1:0]   clu,
  input  logic [LOC_W-1:0]   lsb,
  output logic [NUM_CLU-1:0] clu_sel,
  output logic               hit,
  output logic [PORT_W-1:0]  port
);
  localparam int ENTRIES = 1 << LOC_W;

  logic [NUM_CLU-1:0] sub_hit;
  logic [PORT_W-1:0]  sub_port [NUM_CLU];

  for (genvar c = 0; c < NUM_CLU; c++) begin : g_clu
    logic              e_hit  [ENTRIES];
    logic [PORT_W-1:0] e_port [ENTRIES];
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam int P = route_pkg::loc_port(c, e, PORTS);
      assign e_hit[e]  = (P >= 0);
      assign e_port[e] = (P >= 0) ? PORT_W'(P) : '0;
    end
    assign clu_sel[c]  = glb_hit && (clu == CLU_W'(c));
    assign sub_hit[c]  = clu_sel[c] && e_hit[lsb];
    assign sub_port[c] = clu_sel[c] ? e_port[lsb] : '0;
  end

  always_comb begin
    port = '0;
    for (int c = 0; c < NUM_CLU; c++) port = port | sub_port[c];
  end

  assign hit = |sub_hit;
endmodule

// File: rtl/cache_class.sv
module cache_class #(
  parameter int          ADDR_W = 32,
  parameter logic [63:0] MASK   = 64'h000C_0000,
  parameter logic [3:0]  TBL    = 4'b0110
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        cls,
  output logic              cacheable
);
  localparam int LO = route_pkg::low_bit(MASK);

  assign cls       = addr[LO +: 2];
  assign cacheable = TBL[cls];
endmodule

// File: rtl/route_decoder.sv
module route_decoder #(
  parameter int          ADDR_W    = 32,
  parameter int          GLB_W     = 8,
  parameter int          LOC_W     = 4,
  parameter int          SRC_GLB_W = 8,
  parameter int          SRC_LOC_W = 2,
  parameter int          NUM_CLU   = 4,
  parameter int          PORTS     = 4,
  parameter logic [63:0] CMASK     = 64'h000C_0000,
  parameter logic [3:0]  CTBL      = 4'b0110,
  parameter bit          PIPE      = 1'b1,
  localparam int CLU_W  = GLB_W,
  localparam int PORT_W = $clog2(PORTS),
  localparam int SRC_W  = SRC_GLB_W + SRC_LOC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [SRC_W-1:0]     srcid,
  output logic                 out_valid,
  output logic [CLU_W-1:0]     clu_idx,
  output logic [PORT_W-1:0]    port_idx,
  output logic                 cacheable,
  output logic                 dec_err,
  output logic [SRC_GLB_W-1:0] rsp_clu,
  output logic [SRC_LOC_W-1:0] rsp_loc
);
  localparam int MSB_LO = ADDR_W - GLB_W;
  localparam int LSB_LO = MSB_LO - LOC_W;

  logic               glb_hit, loc_hit, cache_c, err_c;
  logic [CLU_W-1:0]   glb_clu, clu_c;
  logic [PORT_W-1:0]  loc_prt, port_c;
  logic [NUM_CLU-1:0] clu_sel;
  logic [1:0]         cls;

  glb_table #(.GLB_W(GLB_W), .CLU_W(CLU_W), .NUM_CLU(NUM_CLU)) u_glb (
    .msb(addr[MSB_LO +: GLB_W]), .hit(glb_hit), .clu(glb_clu)
  );

  loc_table #(.LOC_W(LOC_W), .CLU_W(CLU_W), .NUM_CLU(NUM_CLU), .PORTS(PORTS)) u_loc (
    .glb_hit(glb_hit), .clu(glb_clu), .lsb(addr[LSB_LO +: LOC_W]),
    .clu_sel(clu_sel), .hit(loc_hit), .port(loc_prt)
  );

  cache_class #(.ADDR_W(ADDR_W), .MASK(CMASK), .TBL(CTBL)) u_cache (
    .addr(addr), .cls(cls), .cacheable(cache_c)
  );

  assign err_c  = !(glb_hit && loc_hit);
  assign clu_c  = err_c ? '0 : glb_clu;
  assign port_c = err_c ? '0 : loc_prt;

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        clu_idx   <= '0;
        port_idx  <= '0;
        cacheable <= 1'b0;
        dec_err   <= 1'b0;
        rsp_clu   <= '0;
        rsp_loc   <= '0;
      end else begin
        out_valid <= in_valid;
        clu_idx   <= clu_c;
        port_idx  <= port_c;
        cacheable <= cache_c;
        dec_err   <= err_c;
        rsp_clu   <= srcid[SRC_LOC_W +: SRC_GLB_W];
        rsp_loc   <= srcid[SRC_LOC_W-1:0];
      end
    end

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7
    rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ({rsp_clu, rsp_loc} == $past(srcid)));

    // R5
    glb_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(addr[MSB_LO +: GLB_W]) >= GLB_W'(NUM_CLU))) |-> dec_err);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign clu_idx   = clu_c;
    assign port_idx  = port_c;
    assign cacheable = cache_c;
    assign dec_err   = err_c;
    assign rsp_clu   = srcid[SRC_LOC_W +: SRC_GLB_W];
    assign rsp_loc   = srcid[SRC_LOC_W-1:0];
  end

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (clu_idx == '0 && port_idx == '0));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clu_sel));
endmodule

// File: tb/test_route_decoder.sv
module test_route_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] addr = '0;
  logic [9:0]  srcid = '0;
  logic        out_valid, cacheable, dec_err;
  logic [7:0]  clu_idx, rsp_clu;
  logic [1:0]  port_idx, rsp_loc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] clu;
    logic [1:0] prt;
    logic       cch;
    logic       err;
    logic [7:0] rc;
    logic [1:0] rl;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  route_decoder i_route_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr), .srcid(srcid),
    .out_valid(out_valid), .clu_idx(clu_idx), .port_idx(port_idx),
    .cacheable(cacheable), .dec_err(dec_err), .rsp_clu(rsp_clu), .rsp_loc(rsp_loc)
  );

  function automatic exp_t model(input logic [31:0] a, input logic [9:0] s, input string tag);
    exp_t e;
    int g, l, c;
    g = int'(a >> 24);
    l = int'((a >> 20) & 32'hF);
    e.err = 1'b1; e.clu = 0; e.prt = 0;
    case (g)
      0: c = 3;
      1: c = 2;
      2: c = 1;
      3: c = 0;
      default: c = -1;
    endcase
    if (c >= 0 && l <= c + 1) begin
      e.err = 1'b0;
      e.clu = 8'(c);
      e.prt = 2'((l + c + 3) & 3);
    end
    case ((a >> 18) & 32'h3)
      32'd1, 32'd2: e.cch = 1'b1;
      default:      e.cch = 1'b0;
    endcase
    e.rc  = 8'(s / 4);
    e.rl  = 2'(s % 4);
    e.tag = tag;
    return e;
  endfunction

  task automatic apply(input logic [31:0] a, input logic [9:0] s, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    addr     = a;
    srcid    = s;
    sb.push_back(model(a, s, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      addr     = $urandom;
      srcid    = 10'($urandom);
    end
  endtask

  // Monitor: results appear one edge after the vector was applied.
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #2;
      if (done) break;
      checks++;
      if (out_valid !== (sb.size() > 0)) begin
        fails++;
        $display("FAIL R8 out_valid actual=%b expected=%b", out_valid, sb.size() > 0);
      end
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if ({clu_idx, port_idx, cacheable, dec_err, rsp_clu, rsp_loc} !==
            {e.clu, e.prt, e.cch, e.err, e.rc, e.rl}) begin
          fails++;
          $display("FAIL %s actual clu=%0d prt=%0d cch=%b err=%b rc=%0d rl=%0d expected clu=%0d prt=%0d cch=%b err=%b rc=%0d rl=%0d",
                   e.tag, clu_idx, port_idx, cacheable, dec_err, rsp_clu, rsp_loc,
                   e.clu, e.prt, e.cch, e.err, e.rc, e.rl);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R9: outputs held at zero during reset, even with inputs toggling
    addr = 32'h0005_0000; srcid = 10'h3FF;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({out_valid, clu_idx, port_idx, cacheable, dec_err, rsp_clu, rsp_loc} !== '0) begin
      fails++;
      $display("FAIL R9 reset outputs actual=%h expected=0",
               {out_valid, clu_idx, port_idx, cacheable, dec_err, rsp_clu, rsp_loc});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R4 example, together with a response split
    apply(32'h0005_0000, 10'h0E, "R4");
    // R1: every populated global slot
    apply(32'h0000_0000, 10'h3FF, "R1");
    apply(32'h0100_0000, 10'h001, "R1");
    apply(32'h0200_0000, 10'h2A6, "R1");
    apply(32'h0300_0000, 10'h155, "R1");
    idle(2);
    // R2: local entries of each cluster, including the top populated one
    for (int g = 0; g < 4; g++)
      for (int l = 0; l < 6; l++)
        apply({8'(g), 4'(l), 20'h0}, 10'(g * 37 + l), "R2");
    // R6: unpopulated local entries, back to back with hits
    apply(32'h0320_0000, 10'h012, "R6");
    apply(32'h0310_0000, 10'h013, "R6");
    apply(32'h00F0_0000, 10'h014, "R6");
    apply(32'h0250_0000, 10'h015, "R6");
    // R5: unpopulated global slots
    apply(32'h0400_0000, 10'h020, "R5");
    apply(32'hFF00_0000, 10'h021, "R5");
    apply(32'h8010_0000, 10'h022, "R5");
    idle(1);
    // R4: all four address classes
    for (int k = 0; k < 4; k++)
      apply({8'h01, 4'h1, 2'(k), 18'h0}, 10'(k), "R4");
    // R3: offset bits only; routing must not move
    apply(32'h0010_0000, 10'h100, "R3");
    apply(32'h0013_FFFF, 10'h101, "R3");
    apply(32'h0012_A5A5, 10'h102, "R3");
    // R7: source identifier extremes
    apply(32'h0400_0000, 10'h3FC, "R7");
    apply(32'h0400_0000, 10'h003, "R7");
    // R8: sparse valid pattern with mixed addresses
    for (int i = 0; i < 200; i++) begin
      apply({6'h0, 2'($urandom), 4'($urandom), 20'($urandom)}, 10'($urandom), "R8");
      if (i % 3 == 0) idle(1 + i % 2);
    end
    idle(3);
    done = 1'b1;
    @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule